// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of an accumulator-style processor. Each cycle it can accept one operation: a 4-bit operation code, the accumulator value, a second operand (a register, an immediate, a memory word or a shift count) and the current condition flags. One clock later it returns the result and the updated flags. Each operation rewrites only the flags it defines. Every other flag is passed through from the incoming flag vector, so the surrounding core can write the flag register back without any masking.

The operations are:
- add with carry and subtract with borrow;
- bitwise AND, OR and XOR;
- logical and arithmetic shifts by a variable count;
- rotates through carry;
- compare;
- accumulator increment and decrement;
- byte-wide increment and decrement of a memory operand.

Compare produces flags only. It hands back the accumulator unchanged, so a writeback stage that writes the result causes no harm. Decode, the register file, multiply and divide belong to other blocks. The datapath width `W` is a parameter (a power of two, at least 16; 64 by default).

The flag vector, at the input and at the output, is packed as bit 3 = N (negative), bit 2 = V (signed overflow), bit 1 = Z (zero), bit 0 = C (carry). In the requirements, `a` is `in_acc`, `b` is `in_opnd`, `cin` is `in_flags[0]`, and "msb" is bit W-1. Z is set exactly when the value the requirement names for it is zero.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0, `out_result` = 0 and `out_flags` = 0.
- R2: An operation presented with `in_valid` = 1 appears on the outputs after the next rising edge, with `out_valid` = 1. After an edge where `in_valid` = 0, `out_valid` is 0 and `out_result`/`out_flags` keep their previous values.
- R3: Code 0 (add) gives a + b + cin modulo 2^W. C is the carry out of the msb. V is set when a and b have equal sign bits and the result's sign bit differs from them. Z and N are taken from the result.
- R4: Code 1 (subtract) gives a − b − (1 − cin) modulo 2^W. C = 1 when no borrow occurred. V is set when a and b differ in sign and the result's sign differs from a. Z and N are taken from the result.
- R5: Codes 2, 3 and 4 (AND, OR, XOR) update only Z and N from the result. V and C pass through.
- R6: Code 5 (shift left) with count n = b in 1..W gives a << n, and C takes the last bit shifted out, which is a[W−n]. For n > W the result is 0 and C = 0.
- R7: Code 6 (logical right) and code 7 (arithmetic right, sign-filling) shift a right by n. For n ≥ W both give 0. For n ≠ 0, C = a[0].
- R8: Code 8 (rotate left) gives (a << n) with cin ORed into bit 0, and C = a[W−n] for n ≤ W. For n > W the result is cin in bit 0 and C = 0. Code 9 (rotate right) gives (a >> n) with cin placed at bit W−n for n ≤ W, 0 for n > W, and C = a[0].
- R9: Code 10 (compare) returns a unchanged as the result. It computes d = a − b. C = 1 when a ≥ b (unsigned). Z and N are taken from d. V follows the subtract rule of R4, applied to d.
- R10: Code 11 (increment) gives a + 1 and code 12 (decrement) gives a − 1, modulo 2^W. Only Z and N are updated.
- R11: Code 13 (byte increment) and code 14 (byte decrement) take the low 8 bits of b, add or subtract 1 modulo 256, and return that byte zero-extended. Z is taken from the byte, and N is bit 7 of the new byte. V and C pass through.
- R12: For codes 5 to 9 with n = 0, the result equals a and C equals cin. Z and N are taken from a.
- R13: Code 15 returns a as the result and passes all four flags through unchanged.
- R14: Shift and rotate codes (5 to 9) leave V unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_acc | input | W | Accumulator or compared register |
| in_opnd | input | W | Second operand, shift count, or memory word for byte ops |
| in_flags | input | 4 | Current flags {N,V,Z,C} |
| out_valid | output | 1 | Result registered from a valid operation |
| out_result | output | W | Operation result |
| out_flags | output | 4 | Updated flags {N,V,Z,C} |

## Verification
The bench builds the block with W = 16. At this width the shift-count boundaries at 15, 16 and 17 lie inside a sixteen-value operand list. Byte increment and decrement can be told apart from a full-width sign test, because bit 7 is no longer the msb. All sixteen operation codes are swept against 262 accumulator patterns (including the sign and carry edges), every listed operand and both carry values. Each result and flag vector is compared with values computed arithmetically on integers. Directed steps cover reset and the idle hold.

// File: rtl/flag_alu_pkg.sv
// Shared types for the accumulator ALU.
// Assumes: operation codes are fixed by the decode stage and never re-ordered.
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_LSL  = 4'd5,
        OP_LSR  = 4'd6,
        OP_ASR  = 4'd7,
        OP_ROL  = 4'd8,
        OP_ROR  = 4'd9,
        OP_CMP  = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12,
        OP_MINC = 4'd13,
        OP_MDEC = 4'd14,
        OP_PASS = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/flag_alu_addsub.sv
// Shared adder for add, subtract, compare, increment and decrement, plus a
// separate 8-bit incrementer for byte memory operands.
// Assumes: W >= 16. Byte results are zero-extended. For compare, the caller
// discards the difference as a result and only uses it for flags.
module flag_alu_addsub
    import flag_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           c_out,
    output logic           v_out
);

    logic [W-1:0] addend;
    logic         carry_in;
    logic [W-1:0] sum;
    logic         carry;
    logic [7:0]   byte_new;

    // Pick the second adder input and carry-in for each arithmetic code.
    always_comb begin
        addend   = b;
        carry_in = cin;
        case (op)
            OP_SBC:  begin addend = ~b;       carry_in = cin;  end
            OP_CMP:  begin addend = ~b;       carry_in = 1'b1; end
            OP_INC:  begin addend = '0;       carry_in = 1'b1; end
            OP_DEC:  begin addend = '1;       carry_in = 1'b0; end
            default: begin addend = b;        carry_in = cin;  end
        endcase
    end

    // Single W-bit adder with carry out.
    assign {carry, sum} = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, carry_in};

    // Byte path: +1 or -1 on the low byte of the memory operand.
    assign byte_new = (op == OP_MDEC) ? (b[7:0] - 8'd1) : (b[7:0] + 8'd1);

    // Choose the byte or full-width result and derive signed overflow.
    always_comb begin
        if (op == OP_MINC || op == OP_MDEC) begin
            res = {{(W-8){1'b0}}, byte_new};
        end else begin
            res = sum;
        end
        c_out = carry;
        v_out = (a[W-1] == addend[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/flag_alu_logic.sv
// Bitwise unit: AND, OR and XOR of accumulator and operand.
// Assumes: codes other than the three bitwise codes are ignored by the caller.
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);

    // Select the bitwise function.
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            default: res = a ^ b;
        endcase
    end

endmodule

// File: rtl/flag_alu_shift.sv
// Shift and rotate unit with a full-width variable count.
// Assumes: W is a power of two. A count of 0 returns a with carry unchanged.
// Counts beyond the width saturate as the requirements describe.
module flag_alu_shift
    import flag_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   cnt,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           c_out
);

    localparam int           SW    = $clog2(W);
    localparam logic [W-1:0] W_VAL = W'(W);

    logic          cnt_zero;
    logic          cnt_over;
    logic          cnt_full;
    logic [SW:0]   amt;
    logic [W:0]    left_ext;
    logic [W:0]    right_ext;
    logic [W-1:0]  asr_val;

    // Classify the count against the width.
    assign cnt_zero = (cnt == '0);
    assign cnt_over = (cnt > W_VAL);
    assign cnt_full = (cnt >= W_VAL);
    assign amt      = cnt[SW:0];

    // Left shift one bit wider so the last bit out lands in the top bit.
    assign left_ext  = {1'b0, a} << amt;
    // Right rotate through carry: carry sits above a and falls to bit W-n.
    assign right_ext = {cin, a} >> amt;
    // Sign-filling right shift.
    assign asr_val   = $signed(a) >>> cnt[SW-1:0];

    // Select the shifted value and the carry for each code.
    always_comb begin
        res   = a;
        c_out = cin;
        case (op)
            OP_LSL: begin
                res   = cnt_over ? '0   : left_ext[W-1:0];
                c_out = cnt_over ? 1'b0 : left_ext[W];
            end
            OP_LSR: begin
                res   = cnt_full ? '0 : (a >> cnt[SW-1:0]);
                c_out = a[0];
            end
            OP_ASR: begin
                res   = cnt_full ? '0 : asr_val;
                c_out = a[0];
            end
            OP_ROL: begin
                res   = cnt_over ? {{(W-1){1'b0}}, cin}
                                 : (left_ext[W-1:0] | {{(W-1){1'b0}}, cin});
                c_out = cnt_over ? 1'b0 : left_ext[W];
            end
            OP_ROR: begin
                res   = cnt_over ? '0 : right_ext[W-1:0];
                c_out = a[0];
            end
            default: begin
                res   = a;
                c_out = cin;
            end
        endcase
        if (cnt_zero) begin
            res   = a;
            c_out = cin;
        end
    end

endmodule

// File: rtl/flag_alu.sv
// Accumulator ALU with condition flags, one registered stage.
// Routes each code to the arithmetic, bitwise or shift unit, then forms the
// new flag vector. Only the flags a code defines are replaced; the others
// pass through from in_flags.
// Assumes: W is a power of two, W >= 16; flags packed {N,V,Z,C}.
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [3:0]     in_op,
    input  logic [W-1:0]   in_acc,
    input  logic [W-1:0]   in_opnd,
    input  logic [3:0]     in_flags,
    output logic           out_valid,
    output logic [W-1:0]   out_result,
    output logic [3:0]     out_flags
);

    alu_op_e     op;
    alu_flags_t  f_in;
    alu_flags_t  f_nxt;
    logic [W-1:0] r_nxt;

    logic [W-1:0] as_res;
    logic         as_c;
    logic         as_v;
    logic [W-1:0] lg_res;
    logic [W-1:0] sh_res;
    logic         sh_c;

    assign op   = alu_op_e'(in_op);
    assign f_in = alu_flags_t'(in_flags);

    flag_alu_addsub #(.W(W)) u_addsub (
        .op    (op),
        .a     (in_acc),
        .b     (in_opnd),
        .cin   (f_in.c),
        .res   (as_res),
        .c_out (as_c),
        .v_out (as_v)
    );

    flag_alu_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (in_acc),
        .b   (in_opnd),
        .res (lg_res)
    );

    flag_alu_shift #(.W(W)) u_shift (
        .op    (op),
        .a     (in_acc),
        .cnt   (in_opnd),
        .cin   (f_in.c),
        .res   (sh_res),
        .c_out (sh_c)
    );

    // Merge unit outputs into the result and per-code flag updates.
    always_comb begin
        r_nxt = in_acc;
        f_nxt = f_in;
        case (op)
            OP_ADC, OP_SBC: begin
                r_nxt   = as_res;
                f_nxt.c = as_c;
                f_nxt.v = as_v;
                f_nxt.z = (as_res == '0);
                f_nxt.n = as_res[W-1];
            end
            OP_CMP: begin
                r_nxt   = in_acc;
                f_nxt.c = as_c;
                f_nxt.v = as_v;
                f_nxt.z = (as_res == '0);
                f_nxt.n = as_res[W-1];
            end
            OP_INC, OP_DEC: begin
                r_nxt   = as_res;
                f_nxt.z = (as_res == '0);
                f_nxt.n = as_res[W-1];
            end
            OP_MINC, OP_MDEC: begin
                r_nxt   = as_res;
                f_nxt.z = (as_res[7:0] == 8'd0);
                f_nxt.n = as_res[7];
            end
            OP_AND, OP_OR, OP_XOR: begin
                r_nxt   = lg_res;
                f_nxt.z = (lg_res == '0);
                f_nxt.n = lg_res[W-1];
            end
            OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
                r_nxt   = sh_res;
                f_nxt.c = sh_c;
                f_nxt.z = (sh_res == '0);
                f_nxt.n = sh_res[W-1];
            end
            default: begin
                r_nxt = in_acc;
                f_nxt = f_in;
            end
        endcase
    end

    // Output register: load on valid, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_flags  <= 4'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= r_nxt;
                out_flags  <= f_nxt;
            end
        end
    end

endmodule

// File: rtl/flag_alu_chk.sv
// Checker for flag_alu, attached with bind. Observes ports only.
module flag_alu_chk
    import flag_alu_pkg::*;
#(
    parameter int W = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [3:0]     in_op,
    input logic [W-1:0]   in_acc,
    input logic [W-1:0]   in_opnd,
    input logic [3:0]     in_flags,
    input logic           out_valid,
    input logic [W-1:0]   out_result,
    input logic [3:0]     out_flags
);

    localparam logic [W-1:0] W_VAL = W'(W);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0 && out_flags == 4'b0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_flags)));

    // R5
    logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op inside {OP_AND, OP_OR, OP_XOR}))
        |=> ({out_flags[2], out_flags[0]} == $past({in_flags[2], in_flags[0]})));

    // R6
    lsl_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_LSL && in_opnd > W_VAL)
        |=> (out_result == '0 && !out_flags[0]));

    // R9
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CMP) |=> (out_result == $past(in_acc)));

    // R11
    byte_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op inside {OP_MINC, OP_MDEC}))
        |=> (out_result[W-1:8] == '0 && out_flags[3] == out_result[7]));

    // R12
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op inside {OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR}) && in_opnd == '0)
        |=> (out_result == $past(in_acc) && out_flags[0] == $past(in_flags[0])));

    // R14
    shift_v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op inside {OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR}))
        |=> (out_flags[2] == $past(in_flags[2])));

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_acc     (in_acc),
    .in_opnd    (in_opnd),
    .in_flags   (in_flags),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_flags  (out_flags)
);

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;

    localparam int W = 16;
    localparam int M = 1 << W;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic [3:0]     in_op;
    logic [W-1:0]   in_acc;
    logic [W-1:0]   in_opnd;
    logic [3:0]     in_flags;
    logic           out_valid;
    logic [W-1:0]   out_result;
    logic [3:0]     out_flags;

    always #2.5 clk = ~clk;

    flag_alu #(.W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_acc     (in_acc),
        .in_opnd    (in_opnd),
        .in_flags   (in_flags),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_flags  (out_flags)
    );

    int           total = 0;
    int           bad   = 0;
    logic         pend  = 1'b0;
    logic [W-1:0] exp_r;
    logic [3:0]   exp_f;
    string        exp_tag;

    // Requirement tag for a code and count.
    function automatic string tag_of(input int op, input int b);
        if (op >= 5 && op <= 9 && b == 0) return "R12";
        case (op)
            0:          return "R3";
            1:          return "R4";
            2, 3, 4:    return "R5";
            5:          return "R6";
            6, 7:       return "R7";
            8, 9:       return "R8";
            10:         return "R9";
            11, 12:     return "R10";
            13, 14:     return "R11";
            default:    return "R13";
        endcase
    endfunction

    // Reference model written from the requirements with integer arithmetic.
    task automatic model(input int op, input int ai, input int bi, input logic [3:0] fi,
                         output logic [W-1:0] r, output logic [3:0] fo);
        int  ci = int'(fi[0]);
        int  s;
        int  d;
        int  sa;
        int  rv;
        logic n = fi[3], v = fi[2], z = fi[1], c = fi[0];
        logic am = ai[W-1], bm = bi[W-1];
        rv = ai;
        case (op)
            0: begin
                s = ai + bi + ci; rv = s % M; c = (s >= M);
                v = (am == bm) && (rv[W-1] != am);
            end
            1: begin
                s = ai - bi - (1 - ci); rv = (s + 2*M) % M; c = (s >= 0);
                v = (am != bm) && (rv[W-1] != am);
            end
            2: rv = ai & bi;
            3: rv = ai | bi;
            4: rv = ai ^ bi;
            5: if (bi != 0) begin
                rv = (bi >= W) ? 0 : ((ai << bi) % M);
                c  = (bi > W) ? 1'b0 : logic'((ai >> (W - bi)) & 1);
            end
            6: if (bi != 0) begin
                rv = (bi >= W) ? 0 : (ai >> bi); c = logic'(ai & 1);
            end
            7: if (bi != 0) begin
                sa = am ? (ai - M) : ai;
                rv = (bi >= W) ? 0 : ((sa >>> bi) & (M - 1)); c = logic'(ai & 1);
            end
            8: if (bi != 0) begin
                if (bi > W) begin rv = ci; c = 1'b0; end
                else begin
                    rv = ((bi == W) ? 0 : ((ai << bi) % M)) | ci;
                    c  = logic'((ai >> (W - bi)) & 1);
                end
            end
            9: if (bi != 0) begin
                rv = (bi > W) ? 0 : ((bi == W ? 0 : (ai >> bi)) | (ci << (W - bi)));
                c  = logic'(ai & 1);
            end
            10: begin
                s = ai - bi; d = (s + M) % M; rv = ai; c = (ai >= bi);
                v = (am != bm) && (d[W-1] != am);
            end
            11: rv = (ai + 1) % M;
            12: rv = (ai + M - 1) % M;
            13: rv = ((bi & 255) + 1) % 256;
            14: rv = ((bi & 255) + 255) % 256;
            default: rv = ai;
        endcase
        if (op == 10) begin
            d = ((ai - bi) + M) % M;
            z = (d == 0); n = d[W-1];
        end else if (op == 13 || op == 14) begin
            z = (rv == 0); n = rv[7];
        end else if (op != 15) begin
            z = (rv == 0); n = rv[W-1];
        end
        r  = rv[W-1:0];
        fo = {n, v, z, c};
    endtask

    // Compare the registered output with the expectation of the last issue.
    task automatic check_out();
        total++;
        if (out_valid !== 1'b1 || out_result !== exp_r || out_flags !== exp_f) begin
            bad++;
            $display("FAIL %s: got valid=%0b result=%h flags=%b, expected valid=1 result=%h flags=%b",
                     exp_tag, out_valid, out_result, out_flags, exp_r, exp_f);
        end
    endtask

    // Issue one operation at a falling edge; check the previous one there.
    task automatic issue(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] f);
        @(negedge clk);
        if (pend) check_out();
        in_valid = 1'b1;
        in_op    = op[3:0];
        in_acc   = a;
        in_opnd  = b;
        in_flags = f;
        model(op, int'(a), int'(b), f, exp_r, exp_f);
        exp_tag  = tag_of(op, int'(b));
        pend     = 1'b1;
    endtask

    function automatic logic [W-1:0] acc_of(input int i);
        logic [7:0] iv = i[7:0];
        case (i)
            256:     return 16'h0000;
            257:     return 16'h0001;
            258:     return 16'h7FFF;
            259:     return 16'h8000;
            260:     return 16'hFFFF;
            261:     return 16'h8001;
            default: return {iv[7:4], iv[3:0], ~iv[3:0], iv[7:4]};
        endcase
    endfunction

    function automatic logic [W-1:0] opnd_of(input int j);
        case (j)
            0:  return 16'd0;
            1:  return 16'd1;
            2:  return 16'd2;
            3:  return 16'd3;
            4:  return 16'd7;
            5:  return 16'd8;
            6:  return 16'd15;
            7:  return 16'd16;
            8:  return 16'd17;
            9:  return 16'h00FF;
            10: return 16'h0080;
            11: return 16'h7FFF;
            12: return 16'h8000;
            13: return 16'hAAAA;
            14: return 16'hFFFE;
            default: return 16'hFFFF;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=still running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_op    = 4'd0;
        in_acc   = 16'h1234;
        in_opnd  = 16'h0F0F;
        in_flags = 4'hF;
        repeat (3) @(negedge clk);
        // R1: reset state despite a valid operation at the input
        total++;
        if (out_valid !== 1'b0 || out_result !== '0 || out_flags !== 4'b0) begin
            bad++;
            $display("FAIL R1: got valid=%0b result=%h flags=%b, expected valid=0 result=0000 flags=0000",
                     out_valid, out_result, out_flags);
        end
        rst_n    = 1'b1;
        in_valid = 1'b0;

        // Sweep: every code, accumulator patterns, operand list, both carries.
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 262; i++) begin
                for (int j = 0; j < 16; j++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [W-1:0] a = acc_of(i);
                        logic [W-1:0] b = opnd_of(j);
                        issue(op, a, b, {a[5], a[9] ^ b[0], a[2], c[0]});
                    end
                end
            end
        end

        // Final pipelined check, then idle with changed inputs (R2).
        @(negedge clk);
        check_out();
        pend     = 1'b0;
        in_valid = 1'b0;
        in_op    = 4'd11;
        in_acc   = 16'h5A5A;
        in_opnd  = 16'h0001;
        in_flags = 4'b0101;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            total++;
            if (out_valid !== 1'b0 || out_result !== exp_r || out_flags !== exp_f) begin
                bad++;
                $display("FAIL R2: got valid=%0b result=%h flags=%b, expected valid=0 result=%h flags=%b",
                         out_valid, out_result, out_flags, exp_r, exp_f);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule